// File: doc/BRIEF.md
# Dual Accumulator Saturation Controller

This block sits after the adder of a fixed-point datapath that keeps two 40-bit signed accumulators (A and B) in 9.31 format: eight guard bits above a 1.31 fraction. On each write strobe it takes the adder's raw 40-bit result and the adder's bit-39 overflow indication. It then decides, according to a two-bit mode, whether to clamp the result, and loads the outcome into the selected accumulator. Only that accumulator changes.

For each accumulator the block keeps an overflow flag and a sticky saturation flag. The overflow flag reports that the stored value has spilled into the guard bits. The saturation flag records that a clamp or a catastrophic overflow has happened, and software clears it. The block also gives an OR summary of each flag pair. In the wrapping mode it raises a one-cycle trap request when an enabled catastrophic overflow occurs. All flags and accumulators are registered, so a write presented before a rising edge is visible just after it.

Top module: `acc_sat_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators, all four flags, both summaries and `trap_req` are 0 after that edge.
- R2: Mode 2'b00 (40-bit saturation): if `sum_ovf39` is set, the target loads 0x7FFFFFFFFF when the true sum is positive (`sum_in[39]`=1) or 0x8000000000 when it is negative, and its saturation flag sets. Without overflow, `sum_in` is stored unchanged.
- R3: Mode 2'b01 (32-bit saturation): if the true sum lies outside -2^31..2^31-1, including any case with `sum_ovf39` set, the target loads 0x007FFFFFFF (positive) or 0xFF80000000 (negative) and its saturation flag sets. Otherwise `sum_in` is stored unchanged.
- R4: A write in mode 2'b01 leaves the target's overflow flag at 0.
- R5: In modes 2'b00, 2'b10 and 2'b11, a write sets the target's overflow flag to 1 exactly when bits 39..31 of the stored value are not all equal, and to 0 otherwise.
- R6: Mode 2'b10 (wrap): `sum_in` is stored without clamping, and `sum_ovf39` sets the target's saturation flag.
- R7: `trap_req` is high for the one cycle after a write in mode 2'b10 with both `sum_ovf39` and `trap_en` set, and low after every other cycle.
- R8: A saturation flag stays set until its `clr_sat` bit (bit 0 for A, bit 1 for B) is high at an edge. If a setting event and the clear hit the same accumulator in the same cycle, the flag stays set.
- R9: `ovf_any` equals `ovf_a | ovf_b`, and `sat_any` equals `sat_a | sat_b`.
- R10: `tgt_sel`=0 selects A and 1 selects B. A write changes only the selected accumulator and its overflow flag, and with `wr_en` low neither accumulator nor overflow flag changes.
- R11: Mode 2'b11 (raw): `sum_in` is stored unchanged, no saturation flag sets, and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the target accumulator |
| tgt_sel | input | 1 | Target select: 0 = A, 1 = B |
| mode | input | 2 | Saturation mode |
| trap_en | input | 1 | Enables a trap on catastrophic overflow |
| sum_in | input | 40 | Raw adder result |
| sum_ovf39 | input | 1 | Adder overflow out of bit 39 |
| clr_sat | input | 2 | Software clear of the saturation flags (bit 0 A, bit 1 B) |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Guard-bit overflow of A |
| ovf_b | output | 1 | Guard-bit overflow of B |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_any | output | 1 | OR of the overflow flags |
| sat_any | output | 1 | OR of the saturation flags |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The functions that collide are a saturating write and a software clear of the same accumulator's sticky flag. A write to one accumulator can also land together with a clear of the other. The bench provokes the same-accumulator collision with a directed step that overflows accumulator B while `clr_sat[1]` is high, and with random traffic that raises both clear bits often. A behavioural model with set-over-clear priority judges each outcome every clock. The model derives overflow and clamping from the true integer sum, so an error in the priority or in how the clamp sign is chosen shows up as a flag or value mismatch.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;

  typedef enum logic [1:0] {
    MODE_SAT40     = 2'b00,
    MODE_SAT32     = 2'b01,
    MODE_WRAP_TRAP = 2'b10,
    MODE_RAW       = 2'b11
  } sat_mode_e;

endpackage

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp
  import acc_sat_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  sat_mode_e        mode,
  input  logic [ACC_W-1:0] sum,
  input  logic             ovf39,
  input  logic             trap_en,
  output logic [ACC_W-1:0] val,
  output logic             ovf_flag,
  output logic             sat_evt,
  output logic             trap_evt
);

  localparam int LOW_B = ACC_W - GUARD_W - 1;
  localparam int SPAN  = GUARD_W + 1;

  localparam logic [ACC_W-1:0] MAX_WIDE   = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_WIDE   = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_NARROW = {{SPAN{1'b0}}, {LOW_B{1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NARROW = {{SPAN{1'b1}}, {LOW_B{1'b0}}};

  function automatic logic spills(input logic [ACC_W-1:0] v);
    logic [SPAN-1:0] top;
    top = v[ACC_W-1:LOW_B];
    return !((&top) || !(|top));
  endfunction

  logic true_neg;
  logic narrow_out;

  always_comb begin
    true_neg   = ovf39 ? ~sum[ACC_W-1] : sum[ACC_W-1];
    narrow_out = ovf39 || spills(sum);
    val        = sum;
    sat_evt    = 1'b0;
    trap_evt   = 1'b0;
    unique case (mode)
      MODE_SAT40: begin
        if (ovf39) begin
          val     = true_neg ? MIN_WIDE : MAX_WIDE;
          sat_evt = 1'b1;
        end
      end
      MODE_SAT32: begin
        if (narrow_out) begin
          val     = true_neg ? MIN_NARROW : MAX_NARROW;
          sat_evt = 1'b1;
        end
      end
      MODE_WRAP_TRAP: begin
        sat_evt  = ovf39;
        trap_evt = ovf39 && trap_en;
      end
      default: begin
      end
    endcase
    ovf_flag = (mode == MODE_SAT32) ? 1'b0 : spills(val);
  end

  // R2: a wide overflow always produces one of the two wide limits
  always_comb begin
    if (mode == MODE_SAT40 && ovf39) begin
      p_clamp40_r2: assert (val == MAX_WIDE || val == MIN_WIDE);
    end
  end

  // R3: a narrow clamp result always sits inside the 1.31 range
  always_comb begin
    if (mode == MODE_SAT32) begin
      p_narrow_fit_r3: assert (!spills(val));
    end
  end

endmodule

// File: rtl/acc_sat_slice.sv
module acc_sat_slice #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             clr,
  input  logic [ACC_W-1:0] val,
  input  logic             ovf_in,
  input  logic             sat_evt,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q,
  output logic             sat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (wr) begin
        acc_q <= val;
        ovf_q <= ovf_in;
      end
      if (wr && sat_evt) begin
        sat_q <= 1'b1;
      end else if (clr) begin
        sat_q <= 1'b0;
      end
    end
  end

  // R8: sticky until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (sat_q && !clr) |=> sat_q);

  // R8: a setting event wins over a clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && sat_evt) |=> sat_q);

  // R10: an unselected slice holds its value and overflow flag
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(acc_q) && $stable(ovf_q)));

endmodule

// File: rtl/acc_sat_ctrl.sv
module acc_sat_ctrl
  import acc_sat_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             tgt_sel,
  input  logic [1:0]       mode,
  input  logic             trap_en,
  input  logic [ACC_W-1:0] sum_in,
  input  logic             sum_ovf39,
  input  logic [1:0]       clr_sat,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             sat_a,
  output logic             sat_b,
  output logic             ovf_any,
  output logic             sat_any,
  output logic             trap_req
);

  localparam int NUM_ACC = 2;

  sat_mode_e        mode_e;
  logic [ACC_W-1:0] new_val;
  logic             new_ovf;
  logic             new_sat;
  logic             new_trap;
  logic [ACC_W-1:0] acc_arr [NUM_ACC];
  logic [NUM_ACC-1:0] ovf_vec;
  logic [NUM_ACC-1:0] sat_vec;
  logic             trap_q;

  assign mode_e = sat_mode_e'(mode);

  acc_sat_clamp #(
    .ACC_W  (ACC_W),
    .GUARD_W(GUARD_W)
  ) u_clamp (
    .mode    (mode_e),
    .sum     (sum_in),
    .ovf39   (sum_ovf39),
    .trap_en (trap_en),
    .val     (new_val),
    .ovf_flag(new_ovf),
    .sat_evt (new_sat),
    .trap_evt(new_trap)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic sel_here;
    assign sel_here = wr_en && (tgt_sel == g[0]);

    acc_sat_slice #(
      .ACC_W(ACC_W)
    ) u_slice (
      .clk    (clk),
      .rst    (rst),
      .wr     (sel_here),
      .clr    (clr_sat[g]),
      .val    (new_val),
      .ovf_in (new_ovf),
      .sat_evt(new_sat),
      .acc_q  (acc_arr[g]),
      .ovf_q  (ovf_vec[g]),
      .sat_q  (sat_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q <= 1'b0;
    end else begin
      trap_q <= wr_en && new_trap;
    end
  end

  assign acc_a    = acc_arr[0];
  assign acc_b    = acc_arr[1];
  assign ovf_a    = ovf_vec[0];
  assign ovf_b    = ovf_vec[1];
  assign sat_a    = sat_vec[0];
  assign sat_b    = sat_vec[1];
  assign ovf_any  = |ovf_vec;
  assign sat_any  = |sat_vec;
  assign trap_req = trap_q;

  // R7: a trap only follows an enabled wide overflow in wrap mode
  p_trap_cause_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(wr_en && mode == 2'b10 && sum_ovf39 && trap_en));

  // R4: narrow mode never leaves the target's overflow flag set
  p_no_ovf_a_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b01 && !tgt_sel) |=> !ovf_a);
  p_no_ovf_b_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b01 && tgt_sel) |=> !ovf_b);

  // R11: raw mode does not raise a clear saturation flag
  p_raw_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b11 && !tgt_sel && !sat_a && !clr_sat[0]) |=> !sat_a);

endmodule

// File: tb/tb_acc_sat_ctrl.sv
module tb_acc_sat_ctrl;

  localparam longint MAX40 = 64'sh0000_007F_FFFF_FFFF;
  localparam longint MIN40 = -64'sh0000_0080_0000_0000;
  localparam longint MAX32 = 64'sh0000_0000_7FFF_FFFF;
  localparam longint MIN32 = -64'sh0000_0000_8000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic        tgt_sel;
  logic [1:0]  mode;
  logic        trap_en;
  logic [39:0] sum_in;
  logic        sum_ovf39;
  logic [1:0]  clr_sat;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any, trap_req;

  always #4 clk = ~clk;

  acc_sat_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .tgt_sel(tgt_sel), .mode(mode),
    .trap_en(trap_en), .sum_in(sum_in), .sum_ovf39(sum_ovf39), .clr_sat(clr_sat),
    .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .sat_a(sat_a), .sat_b(sat_b), .ovf_any(ovf_any), .sat_any(sat_any),
    .trap_req(trap_req)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  logic [39:0] e_acc [2];
  bit          e_ovf [2];
  bit          e_sat [2];
  bit          e_trap;

  function automatic bit fits32(input logic [39:0] v);
    longint s;
    s = {{24{v[39]}}, v};
    return (s >= MIN32) && (s <= MAX32);
  endfunction

  task automatic chk(input string req, input string what, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "acc_a", acc_a, e_acc[0]);
    chk(cur_req, "acc_b", acc_b, e_acc[1]);
    chk(cur_req, "ovf_a", {39'd0, ovf_a}, {39'd0, e_ovf[0]});
    chk(cur_req, "ovf_b", {39'd0, ovf_b}, {39'd0, e_ovf[1]});
    chk(cur_req, "sat_a", {39'd0, sat_a}, {39'd0, e_sat[0]});
    chk(cur_req, "sat_b", {39'd0, sat_b}, {39'd0, e_sat[1]});
    chk("R7", "trap_req", {39'd0, trap_req}, {39'd0, e_trap});
    chk("R9", "ovf_any", {39'd0, ovf_any}, {39'd0, e_ovf[0] | e_ovf[1]});
    chk("R9", "sat_any", {39'd0, sat_any}, {39'd0, e_sat[0] | e_sat[1]});
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit wr, input bit tgt, input logic [1:0] md, input bit ten,
                      input longint x, input longint y, input logic [1:0] clr);
    longint      t;
    bit          o;
    bit          sev;
    bit          tneg;
    logic [39:0] w;
    logic [39:0] nv;
    t    = x + y;
    o    = (t > MAX40) || (t < MIN40);
    w    = t[39:0];
    tneg = (t < 0);
    wr_en = wr; tgt_sel = tgt; mode = md; trap_en = ten;
    sum_in = w; sum_ovf39 = o; clr_sat = clr;
    @(posedge clk);
    nv  = w;
    sev = 1'b0;
    case (md)
      2'b00: if (o) begin nv = tneg ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF; sev = 1'b1; end
      2'b01: if (t > MAX32 || t < MIN32) begin nv = tneg ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF; sev = 1'b1; end
      2'b10: sev = o;
      default: sev = 1'b0;
    endcase
    for (int i = 0; i < 2; i++) begin
      if (wr && (int'(tgt) == i)) begin
        e_acc[i] = nv;
        e_ovf[i] = (md == 2'b01) ? 1'b0 : !fits32(nv);
      end
      if (wr && (int'(tgt) == i) && sev) e_sat[i] = 1'b1;
      else if (clr[i]) e_sat[i] = 1'b0;
    end
    e_trap = wr && (md == 2'b10) && o && ten;
    @(negedge clk);
    compare_all();
  endtask

  function automatic longint rnd40();
    logic [63:0] r;
    longint      v;
    r = {$urandom(), $urandom()};
    v = {{24{r[39]}}, r[39:0]};
    if ($urandom_range(0, 2) == 0) v = v >>> $urandom_range(0, 39);
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; tgt_sel = 1'b0; mode = 2'b00; trap_en = 1'b0;
    sum_in = '0; sum_ovf39 = 1'b0; clr_sat = 2'b00;
    for (int i = 0; i < 2; i++) begin e_acc[i] = '0; e_ovf[i] = 1'b0; e_sat[i] = 1'b0; end
    e_trap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst = 1'b0;

    // R2: wide clamp both ways, plain pass-through
    cur_req = "R2";
    step(1, 0, 2'b00, 0, MAX40, 1, 2'b00);
    step(1, 0, 2'b00, 0, MIN40, -1, 2'b01);
    step(1, 0, 2'b00, 0, 100, 200, 2'b00);
    // R5: spilled value kept in wide mode sets overflow
    cur_req = "R5";
    step(1, 0, 2'b00, 0, MAX32, 5, 2'b00);
    step(1, 0, 2'b00, 0, -7, 3, 2'b00);

    // R3: narrow clamp, also with a wide overflow underneath
    cur_req = "R3";
    step(1, 1, 2'b01, 0, 64'sh4000_0000, 64'sh4000_0000, 2'b00);
    step(1, 1, 2'b01, 0, MIN32, -1, 2'b10);
    step(1, 1, 2'b01, 0, MAX40, 1, 2'b10);
    step(1, 1, 2'b01, 0, MIN40, -2, 2'b00);
    step(1, 1, 2'b01, 0, MAX32, 0, 2'b00);
    // R4: narrow write drops a previously set overflow flag
    cur_req = "R4";
    step(1, 1, 2'b11, 0, MAX32, 1, 2'b00);
    step(1, 1, 2'b01, 0, 10, 10, 2'b00);

    // R8: sticky, then cleared, then set and clear collide
    cur_req = "R8";
    step(1, 1, 2'b01, 0, MAX32, 9, 2'b00);
    step(1, 1, 2'b01, 0, 1, 1, 2'b00);
    step(0, 1, 2'b01, 0, 0, 0, 2'b10);
    step(1, 1, 2'b00, 0, MAX40, MAX40, 2'b10);
    step(1, 0, 2'b00, 0, MAX40, 3, 2'b10);

    // R6 and R7: wrap mode with and without trap enable
    cur_req = "R6";
    step(0, 0, 2'b00, 0, 0, 0, 2'b11);
    step(1, 0, 2'b10, 1, MAX40, 1, 2'b00);
    step(1, 1, 2'b10, 0, MIN40, -1, 2'b00);
    cur_req = "R7";
    step(1, 0, 2'b10, 1, 5, 6, 2'b00);
    step(1, 0, 2'b00, 1, MAX40, 1, 2'b00);
    step(1, 0, 2'b10, 1, MIN40, -5, 2'b11);

    // R11: raw mode wraps silently
    cur_req = "R11";
    step(0, 0, 2'b00, 0, 0, 0, 2'b11);
    step(1, 0, 2'b11, 1, MAX40, 1, 2'b00);
    step(1, 1, 2'b11, 1, MIN40, -1, 2'b00);

    // R10: idle cycles with busy inputs change nothing
    cur_req = "R10";
    step(0, 0, 2'b00, 1, MAX40, 1, 2'b00);
    step(0, 1, 2'b10, 1, MIN40, -1, 2'b00);
    step(1, 1, 2'b11, 0, 42, 0, 2'b00);

    // mixed random traffic with frequent clears
    cur_req = "random";
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, 1'($urandom()), 2'($urandom()), 1'($urandom()),
           rnd40(), rnd40(), ($urandom_range(0, 3) == 0) ? 2'($urandom()) : 2'b00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule